// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A single-clock synchronous memory in which every operation moves its data exactly two clock edges after its command is sampled, whether it reads or writes. Because both directions have the same delay, reads and writes can follow one another on consecutive cycles with no idle cycle on the data bus. The data bus is split into an input word, an output word and an output drive qualifier, so the block can sit behind a pad ring or feed on-chip logic directly.

Each rising edge samples a read/write select, a three-input chip select, a load/advance control, an address and one active-low write enable per 9-bit lane. A load starts a new operation at the external address. An advance continues the running operation at the next address of a four-beat burst, generated inside the block. An active-low clock enable freezes the whole pipeline. An active-low output enable can mask the drive qualifier at any moment, without a clock.

Top module: `zbt_sram`

## Requirements
- R1: On an edge with `cke_n`=0, `ld_n`=0 and the chip selected, a new operation starts at `addr`: a read when `rd_wr`=1, a write when `rd_wr`=0.
- R2: For a read command sampled at edge n, `dout` holds the addressed word and `dout_en` is 1 from just after edge n+2 until the next enabled edge. Reads and writes may be issued on any consecutive cycles, and a read always returns the most recent earlier write.
- R3: A write command sampled at edge n stores `din` at edge n+2. Only lanes k whose `lane_we_n[k]` was 0 in the command's own cycle are stored. Lane k is bits 9k+8 down to 9k.
- R4: While `cke_n`=1, all other synchronous inputs are ignored: no command is taken, no write occurs, and `dout` and `dout_en` keep their values. Once `cke_n` returns to 0, the pipeline resumes where it stopped.
- R5: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load while not selected starts nothing, and operations already in flight still complete.
- R6: `dout_en` is 0 in the data phase that belongs to a write, a deselected load or an idle advance.
- R7: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge, and does not disturb the pipeline.
- R8: An advance (`ld_n`=1) with no running operation, whether after reset or after a deselected load, does nothing.
- R9: An advance continues the running operation's type, using the lane enables of its own cycle. Its address keeps the upper bits of the loaded address. The low two bits are (base + beat) mod 4, where beat counts 1, 2, 3, 0 and so on; with `BURST_XOR`=1 they are base XOR beat instead.
- R10: While `rst_n`=0 and after its release, `dout_en` is 0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| cke_n | input | 1 | Active-low clock enable; 1 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| rd_wr | input | 1 | 1 read, 0 write |
| ld_n | input | 1 | 0 load new address, 1 advance burst |
| addr | input | AW | Word address |
| lane_we_n | input | LANES | Active-low write enable per 9-bit lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | WIDTH | Write data, taken two edges after its command |
| dout | output | WIDTH | Read data register |
| dout_en | output | 1 | Output drive qualifier |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge, and that `cke_n` is 0 on the first edge after release, so that the stall check never compares against reset-time values. The stimulus drives every input one nanosecond after a rising edge and keeps `cke_n` low around reset. It reads only addresses that were written earlier, so expected words never depend on the memory's initial contents. Burst checks use the default address width, which is wide enough for a two-bit beat field.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH     = 256,
  parameter int WIDTH     = 36,
  parameter int LANE_W    = 9,
  parameter int BURST_XOR = 0,
  parameter int AW        = $clog2(DEPTH),
  parameter int LANES     = WIDTH / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             rd_wr,
  input  logic             ld_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en
);

  logic go, chip_on;
  logic act_r, act_wr_r;
  logic [AW-1:0] base_r;
  logic [1:0] cnt_r, cnt_nx, beat_lo;
  logic [AW-1:0] adv_addr;
  logic s1_vld, s1_wr, s2_vld, s2_wr, drv_r;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;

  assign go      = !cke_n;
  assign chip_on = !sel_a_n && !sel_b_n && sel_c;
  assign cnt_nx  = cnt_r + 2'd1;
  assign beat_lo = (BURST_XOR != 0) ? (base_r[1:0] ^ cnt_nx) : (base_r[1:0] + cnt_nx);
  assign adv_addr = {base_r[AW-1:2], beat_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_r  <= 1'b0;
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      drv_r  <= 1'b0;
    end else if (go) begin
      s2_vld <= s1_vld;
      drv_r  <= s2_vld && !s2_wr;
      if (!ld_n) begin
        act_r  <= chip_on;
        s1_vld <= chip_on;
      end else begin
        s1_vld <= act_r;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      s1_be   <= lane_we_n;
      if (!ld_n) begin
        act_wr_r <= !rd_wr;
        s1_wr    <= !rd_wr;
        base_r   <= addr;
        cnt_r    <= 2'd0;
        s1_addr  <= addr;
      end else begin
        s1_wr   <= act_wr_r;
        cnt_r   <= cnt_nx;
        s1_addr <= adv_addr;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lmem [DEPTH];
    logic [LANE_W-1:0] q_l;
    always_ff @(posedge clk) begin
      if (go && s2_vld) begin
        if (s2_wr && !s2_be[k]) lmem[s2_addr] <= din[k*LANE_W +: LANE_W];
        if (!s2_wr) q_l <= lmem[s2_addr];
      end
    end
    assign dout[k*LANE_W +: LANE_W] = q_l;
  end

  assign dout_en = drv_r && !oe_n;

  a_r1_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && chip_on) |=> (s1_vld && s1_addr == $past(addr) && s1_wr == !$past(rd_wr)));

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(drv_r) && $stable(s1_vld) && $stable(s2_vld) && $stable(act_r)));

  a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && !chip_on) |=> (!s1_vld && !act_r));

  a_r6_write_release: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s2_vld && s2_wr) |=> !dout_en);

  a_r8_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n && !act_r) |=> !s1_vld);

  a_r9_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n && act_r) |=> (s1_vld && s1_addr[AW-1:2] == $past(base_r[AW-1:2])
                               && s1_addr[1:0] != $past(s1_addr[1:0])));

endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int AW = 8, W = 36, NL = 4, LW = 9;

  logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b_n = 1'b0, sel_c = 1'b1;
  logic rd_wr = 1'b1, ld_n = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_we_n = '1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_en;

  zbt_sram u_dut (.clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .rd_wr(rd_wr), .ld_n(ld_n), .addr(addr),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en));

  always #4 clk = !clk;

  int checks = 0, failures = 0, seq_id = 0, n_slots = 0;
  logic [W-1:0] ref_mem [256];

  logic          s_adv  [32];
  logic          s_rd   [32];
  logic [AW-1:0] s_addr [32];
  logic [NL-1:0] s_be   [32];
  logic [2:0]    s_sel  [32];
  logic          o_vld  [32];
  logic          o_wr   [32];
  logic [W-1:0]  o_dat  [32];

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    ld_n = 1'b0; rd_wr = 1'b1; {sel_a_n, sel_b_n, sel_c} = 3'b101; lane_we_n = '1;
  endtask

  task automatic ld(input logic rd, input logic [AW-1:0] a, input logic [NL-1:0] be, input logic [2:0] sel);
    s_adv[n_slots] = 1'b0; s_rd[n_slots] = rd; s_addr[n_slots] = a;
    s_be[n_slots] = be; s_sel[n_slots] = sel; n_slots++;
  endtask

  task automatic adv(input logic rd, input logic [NL-1:0] be);
    s_adv[n_slots] = 1'b1; s_rd[n_slots] = rd; s_addr[n_slots] = 8'hEE;
    s_be[n_slots] = be; s_sel[n_slots] = 3'b100; n_slots++;
  endtask

  function automatic logic [W-1:0] wdat(input int j);
    logic [63:0] h;
    h = 64'(j + 1) * 64'h9E3779B97F4A7C15 + 64'(seq_id) * 64'h5A5A5A5;
    return h[W+3:4];
  endfunction

  task automatic run_seq(input string tag);
    logic act = 1'b0, awr = 1'b0;
    logic [AW-1:0] base = '0, oa;
    logic [1:0] cnt = 2'd0;
    for (int j = 0; j < n_slots; j++) begin
      o_vld[j] = 1'b0; o_wr[j] = 1'b0; oa = '0;
      if (!s_adv[j]) begin
        act = (s_sel[j] == 3'b001);
        if (act) begin
          awr = !s_rd[j]; base = s_addr[j]; cnt = 2'd0;
          o_vld[j] = 1'b1; o_wr[j] = awr; oa = base;
        end
      end else if (act) begin
        cnt = cnt + 2'd1;
        o_vld[j] = 1'b1; o_wr[j] = awr;
        oa = {base[AW-1:2], 2'(base[1:0] + cnt)};
      end
      if (o_vld[j] && o_wr[j]) begin
        o_dat[j] = wdat(j);
        for (int k = 0; k < NL; k++)
          if (!s_be[j][k]) ref_mem[oa][k*LW +: LW] = o_dat[j][k*LW +: LW];
      end else if (o_vld[j]) begin
        o_dat[j] = ref_mem[oa];
      end
    end
    for (int i = 0; i < n_slots + 2; i++) begin
      if (i < n_slots) begin
        ld_n = s_adv[i]; rd_wr = s_rd[i]; addr = s_addr[i]; lane_we_n = s_be[i];
        {sel_a_n, sel_b_n, sel_c} = s_sel[i];
      end else idle_in();
      din = ~wdat(i + 100);
      if (i >= 2 && o_vld[i-2] && o_wr[i-2]) din = o_dat[i-2];
      tick();
      if (i >= 2) begin
        if (o_vld[i-2] && !o_wr[i-2]) begin
          chk(dout_en === 1'b1, tag, W'(dout_en), W'(1));
          chk(dout === o_dat[i-2], tag, dout, o_dat[i-2]);
        end else begin
          chk(dout_en === 1'b0, tag, W'(dout_en), W'(0));
        end
      end
    end
    n_slots = 0;
    seq_id++;
  endtask

  task automatic t_reset();
    idle_in();
    tick();
    chk(dout_en === 1'b0, "R10 during reset", W'(dout_en), W'(0));
    rst_n = 1'b1;
    ld_n = 1'b1; rd_wr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(dout_en === 1'b0, "R10 after release", W'(dout_en), W'(0));
    end
    idle_in();
    tick(); tick();
  endtask

  task automatic t_basic();
    ld(0, 8'd5, 4'h0, 3'b001); ld(0, 8'd6, 4'h0, 3'b001);
    ld(1, 8'd5, 4'hF, 3'b001); ld(1, 8'd6, 4'hF, 3'b001);
    ld(0, 8'd8, 4'h0, 3'b001); ld(0, 8'd9, 4'h0, 3'b001);
    run_seq("R1");
  endtask

  task automatic t_lanes();
    ld(0, 8'd5, 4'b1010, 3'b001); ld(1, 8'd5, 4'hF, 3'b001);
    ld(0, 8'd6, 4'b0111, 3'b001); ld(1, 8'd6, 4'hF, 3'b001);
    run_seq("R3");
  endtask

  task automatic t_mix();
    ld(1, 8'd5, 4'hF, 3'b001); ld(0, 8'd7, 4'h0, 3'b001); ld(1, 8'd7, 4'hF, 3'b001);
    ld(0, 8'd5, 4'h0, 3'b001); ld(1, 8'd5, 4'hF, 3'b001); ld(1, 8'd6, 4'hF, 3'b001);
    ld(0, 8'd6, 4'b1100, 3'b001); ld(1, 8'd6, 4'hF, 3'b001);
    run_seq("R2");
  endtask

  task automatic t_deselect();
    ld(1, 8'd6, 4'hF, 3'b001); ld(0, 8'd8, 4'h0, 3'b101);
    ld(0, 8'd8, 4'h0, 3'b011); ld(1, 8'd6, 4'hF, 3'b000);
    ld(1, 8'd8, 4'hF, 3'b001); ld(0, 8'd9, 4'h0, 3'b111);
    ld(1, 8'd9, 4'hF, 3'b001);
    run_seq("R5");
  endtask

  task automatic t_release();
    ld(0, 8'd10, 4'h0, 3'b001); ld(1, 8'd5, 4'hF, 3'b001);
    ld(0, 8'd11, 4'h0, 3'b001); ld(0, 8'd12, 4'h0, 3'b001);
    ld(1, 8'd10, 4'hF, 3'b001);
    run_seq("R6");
  endtask

  task automatic t_idle_adv();
    ld(1, 8'd5, 4'hF, 3'b101); adv(1, 4'hF); adv(0, 4'h0);
    ld(1, 8'd10, 4'hF, 3'b001); ld(1, 8'd11, 4'hF, 3'b101); adv(0, 4'h0); adv(1, 4'hF);
    ld(1, 8'd11, 4'hF, 3'b001);
    run_seq("R8");
  endtask

  task automatic t_burst();
    ld(0, 8'd12, 4'h0, 3'b001); adv(1, 4'h0); adv(1, 4'h0); adv(1, 4'h0);
    ld(1, 8'd13, 4'hF, 3'b001); adv(0, 4'hF); adv(0, 4'hF); adv(0, 4'hF); adv(0, 4'hF);
    ld(0, 8'd21, 4'h0, 3'b001); adv(0, 4'b0101); adv(0, 4'h0); adv(0, 4'h0);
    ld(1, 8'd20, 4'hF, 3'b001); adv(1, 4'hF); adv(1, 4'hF); adv(1, 4'hF);
    run_seq("R9");
  endtask

  task automatic t_stall();
    logic [W-1:0] held;
    ld_n = 1'b0; rd_wr = 1'b1; addr = 8'd5; {sel_a_n, sel_b_n, sel_c} = 3'b001;
    tick();
    cke_n = 1'b1; rd_wr = 1'b0; lane_we_n = '0; din = ~ref_mem[5];
    tick(); tick();
    chk(dout_en === 1'b0, "R4 no early data", W'(dout_en), W'(0));
    cke_n = 1'b0; idle_in();
    tick(); tick();
    chk(dout_en === 1'b1, "R4 resumed read en", W'(dout_en), W'(1));
    chk(dout === ref_mem[5], "R4 resumed read data", dout, ref_mem[5]);
    held = dout;
    cke_n = 1'b1; ld_n = 1'b0; rd_wr = 1'b1; addr = 8'd6; {sel_a_n, sel_b_n, sel_c} = 3'b001;
    tick(); tick();
    chk(dout_en === 1'b1, "R4 held en", W'(dout_en), W'(1));
    chk(dout === held, "R4 held data", dout, held);
    cke_n = 1'b0; idle_in();
    tick();
    chk(dout_en === 1'b0, "R4 released", W'(dout_en), W'(0));
    tick(); tick();
    ld(1, 8'd5, 4'hF, 3'b001);
    run_seq("R4");
  endtask

  task automatic t_oe();
    ld_n = 1'b0; rd_wr = 1'b1; addr = 8'd6; {sel_a_n, sel_b_n, sel_c} = 3'b001;
    tick();
    idle_in();
    tick(); tick();
    chk(dout_en === 1'b1, "R7 enabled", W'(dout_en), W'(1));
    oe_n = 1'b1;
    #1;
    chk(dout_en === 1'b0, "R7 masked", W'(dout_en), W'(0));
    oe_n = 1'b0;
    #1;
    chk(dout_en === 1'b1, "R7 unmasked", W'(dout_en), W'(1));
    chk(dout === ref_mem[6], "R7 data kept", dout, ref_mem[6]);
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_mix();
    t_deselect();
    t_release();
    t_idle_adv();
    t_burst();
    t_stall();
    t_oe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule